// File: doc/BRIEF.md
# Cache Range Flush Sequencer

This block takes a request to flush a virtual address range from a virtually indexed cache and turns it into a stream of per-line flush commands. The request is a base address and a byte length. The block chooses the cheapest granularity that covers the range. A range shorter than a page walks only the lines it touches. A range of a few pages walks every line of those pages. Larger ranges flush one segment, one region or the whole context, and each of these walks as many lines as the cache holds.

Each command carries a line-aligned address and a two-bit kind that names the flush space the cache must apply. Commands leave over a valid/ready handshake. The block is busy from acceptance until the last command is taken, and it then pulses `done`. If the cache is marked absent, or the covered range holds no line, the request still completes, but no command is issued. Per-granularity request counters are kept as status outputs.

Top module: `range_flush_seq`

## Requirements
- R1: When `cache_en` is low at acceptance, no command is issued. `done` is high in the cycle after acceptance and `busy` stays low.
- R2: A request with length below one page uses line granularity. The start is the base rounded down to a line boundary, the count is (base offset within its line + length + line size - 1) / line size, and every command has kind 0.
- R3: If the length is at least one page, the page count is (offset within page + length + page size - 1) / page size. If that count is below cache size / page size, the block issues kind 0 commands for every line of those pages, starting at the page-aligned base. This is page count times lines per page.
- R4: If the page count is at least that threshold and the range lies inside exactly one segment, the block issues cache size / line size commands of kind 1 from the segment-aligned base.
- R5: Otherwise, if the range lies inside exactly one region, the block issues cache size / line size commands of kind 2 from the region-aligned base.
- R6: Otherwise the block issues cache size / line size commands of kind 3, starting at address 0.
- R7: Every command address is line aligned. Each accepted command is followed by one exactly one line size higher, and the kind does not change within a request.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command address and kind stay unchanged and `cmd_valid` stays high.
- R9: `busy` is high from the cycle after acceptance until the last command handshake. `req_ready` is low while `busy` is high, and a request offered then is ignored. `done` is high for exactly the one cycle after the last handshake.
- R10: `cnt_total` counts every accepted request. Each enabled request adds one to exactly one of `cnt_line`, `cnt_page`, `cnt_seg`, `cnt_reg` or `cnt_ctx`, the one matching the chosen granularity. A request with `cache_en` low adds to `cnt_total` only.
- R11: An enabled line-granularity request whose computed count is zero completes as in R1, with no command. A zero-length request with a nonzero offset within its line still issues one command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache present and enabled; low makes requests complete with no commands |
| req_valid | input | 1 | Flush request offered |
| req_ready | output | 1 | Request can be accepted (block idle) |
| req_base | input | ADDR_W | Base virtual address of the range |
| req_len | input | LEN_W | Length of the range in bytes |
| cmd_valid | output | 1 | Flush command present |
| cmd_ready | input | 1 | Cache takes the command |
| cmd_addr | output | ADDR_W | Line-aligned address of the command |
| cmd_kind | output | 2 | Flush space: 0 line/page, 1 segment, 2 region, 3 context |
| busy | output | 1 | A request is being walked |
| done | output | 1 | One-cycle completion pulse |
| cnt_total | output | STAT_W | Accepted requests |
| cnt_line | output | STAT_W | Requests flushed by lines |
| cnt_page | output | STAT_W | Requests flushed by pages |
| cnt_seg | output | STAT_W | Requests flushed as one segment |
| cnt_reg | output | STAT_W | Requests flushed as one region |
| cnt_ctx | output | STAT_W | Requests flushed as the whole context |

## Verification
The first command is due with `busy` in the cycle right after the accepting edge. Each later command is due in the cycle after the previous handshake. `done` follows the last handshake by one cycle, or follows the accepting edge by one cycle when there is no work. The counters update on the accepting edge. The bench drives inputs on falling edges and reads outputs at the same falling edges, so each value is sampled half a cycle after the rising edge that produced it. It throttles `cmd_ready` so that stalled cycles, in which the command must hold, occur within every walk. It checks `done` both in the cycle where it must be high and in the cycle after, where it must be low again.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    GR_LINE = 3'd0,
    GR_PAGE = 3'd1,
    GR_SEG  = 3'd2,
    GR_REG  = 3'd3,
    GR_CTX  = 3'd4,
    GR_NONE = 3'd5
  } gran_t;

  localparam int NUM_GRAN = 5;

  typedef enum logic [1:0] {
    CK_PAGE = 2'd0,
    CK_SEG  = 2'd1,
    CK_REG  = 2'd2,
    CK_CTX  = 2'd3
  } cmd_kind_t;

  // Flush space applied by the cache for a chosen granularity.
  function automatic cmd_kind_t kind_of(input gran_t g);
    case (g)
      GR_SEG:  return CK_SEG;
      GR_REG:  return CK_REG;
      GR_CTX:  return CK_CTX;
      default: return CK_PAGE;
    endcase
  endfunction

endpackage

// File: rtl/rfs_classify.sv
module rfs_classify
  import rfs_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 32,
  parameter int LINE_SH  = 5,
  parameter int PAGE_SH  = 12,
  parameter int SEG_SH   = 18,
  parameter int REG_SH   = 24,
  parameter int CACHE_SH = 16,
  parameter int CW       = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  output gran_t             gran,
  output logic [ADDR_W-1:0] start,
  output logic [CW-1:0]     count
);

  localparam int SW            = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;
  localparam int CACHE_LINES   = 1 << (CACHE_SH - LINE_SH);
  localparam int PAGE_LINES_SH = PAGE_SH - LINE_SH;
  localparam int PAGE_THRESH   = 1 << (CACHE_SH - PAGE_SH);

  // Number of 2**sh sized blocks touched by [a, a+l).
  function automatic logic [SW-1:0] units_spanned(input logic [ADDR_W-1:0] a,
                                                  input logic [LEN_W-1:0]  l,
                                                  input int                sh);
    logic [SW-1:0] mask;
    logic [SW-1:0] off;
    mask = (SW'(1) << sh) - SW'(1);
    off  = SW'(a) & mask;
    return (off + SW'(l) + mask) >> sh;
  endfunction

  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                   input int                sh);
    logic [ADDR_W-1:0] keep;
    keep = {ADDR_W{1'b1}} << sh;
    return a & keep;
  endfunction

  logic [SW-1:0] lines_n, pages_n, segs_n, regs_n;
  logic          short_range;

  always_comb begin
    lines_n     = units_spanned(base, len, LINE_SH);
    pages_n     = units_spanned(base, len, PAGE_SH);
    segs_n      = units_spanned(base, len, SEG_SH);
    regs_n      = units_spanned(base, len, REG_SH);
    short_range = SW'(len) < (SW'(1) << PAGE_SH);

    if (short_range) begin
      gran  = GR_LINE;
      start = align_down(base, LINE_SH);
      count = CW'(lines_n);
    end else if (pages_n < SW'(PAGE_THRESH)) begin
      gran  = GR_PAGE;
      start = align_down(base, PAGE_SH);
      count = CW'(pages_n << PAGE_LINES_SH);
    end else if (segs_n == SW'(1)) begin
      gran  = GR_SEG;
      start = align_down(base, SEG_SH);
      count = CW'(CACHE_LINES);
    end else if (regs_n == SW'(1)) begin
      gran  = GR_REG;
      start = align_down(base, REG_SH);
      count = CW'(CACHE_LINES);
    end else begin
      gran  = GR_CTX;
      start = '0;
      count = CW'(CACHE_LINES);
    end
  end

endmodule

// File: rtl/rfs_issue.sv
module rfs_issue
  import rfs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LINE_SH = 5,
  parameter int CW      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              skip,
  input  logic [ADDR_W-1:0] ld_start,
  input  logic [CW-1:0]     ld_count,
  input  cmd_kind_t         ld_kind,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output cmd_kind_t         cmd_kind,
  output logic              busy,
  output logic              done,
  output logic              hs,
  output logic              last_hs
);

  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(1) << LINE_SH;

  logic [CW-1:0] remaining;

  assign cmd_valid = busy;
  assign hs        = busy && cmd_ready;
  assign last_hs   = hs && (remaining == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      cmd_addr  <= '0;
      cmd_kind  <= CK_PAGE;
      remaining <= '0;
    end else begin
      done <= skip;
      if (load) begin
        busy      <= 1'b1;
        cmd_addr  <= ld_start;
        cmd_kind  <= ld_kind;
        remaining <= ld_count;
      end else if (hs) begin
        if (last_hs) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cmd_addr  <= cmd_addr + LINE_STEP;
          remaining <= remaining - CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/rfs_stats.sv
module rfs_stats
  import rfs_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             inc,
  input  gran_t                            gran,
  output logic [STAT_W-1:0]                total,
  output logic [NUM_GRAN-1:0][STAT_W-1:0]  per_gran
);

  always_ff @(posedge clk) begin
    if (!rst_n)   total <= '0;
    else if (inc) total <= total + STAT_W'(1);
  end

  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        per_gran[g] <= '0;
      else if (inc && (gran == gran_t'(g)))
        per_gran[g] <= per_gran[g] + STAT_W'(1);
    end
  end

endmodule

// File: rtl/range_flush_seq.sv
module range_flush_seq
  import rfs_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 32,
  parameter int LINE_SH  = 5,
  parameter int PAGE_SH  = 12,
  parameter int SEG_SH   = 18,
  parameter int REG_SH   = 24,
  parameter int CACHE_SH = 16,
  parameter int STAT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [LEN_W-1:0]  req_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        cmd_kind,
  output logic              busy,
  output logic              done,
  output logic [STAT_W-1:0] cnt_total,
  output logic [STAT_W-1:0] cnt_line,
  output logic [STAT_W-1:0] cnt_page,
  output logic [STAT_W-1:0] cnt_seg,
  output logic [STAT_W-1:0] cnt_reg,
  output logic [STAT_W-1:0] cnt_ctx
);

  localparam int CACHE_LINES = 1 << (CACHE_SH - LINE_SH);
  localparam int PAGE_LINES  = 1 << (PAGE_SH - LINE_SH);
  localparam int CW          = $clog2(CACHE_LINES + PAGE_LINES + 2);

  // Named internal events, observed by the bound checker.
  gran_t                           cls_gran;
  gran_t                           eff_gran;
  logic [ADDR_W-1:0]               cls_start;
  logic [CW-1:0]                   cls_count;
  logic                            accept;
  logic                            no_work;
  logic                            load;
  logic                            skip;
  logic                            hs;
  logic                            last_hs;
  cmd_kind_t                       kind_q;
  logic [NUM_GRAN-1:0][STAT_W-1:0] per_gran;

  rfs_classify #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_SH(LINE_SH), .PAGE_SH(PAGE_SH),
    .SEG_SH(SEG_SH), .REG_SH(REG_SH), .CACHE_SH(CACHE_SH), .CW(CW)
  ) u_classify (
    .base  (req_base),
    .len   (req_len),
    .gran  (cls_gran),
    .start (cls_start),
    .count (cls_count)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign no_work   = !cache_en || (cls_count == '0);
  assign load      = accept && !no_work;
  assign skip      = accept && no_work;
  assign eff_gran  = cache_en ? cls_gran : GR_NONE;

  rfs_issue #(
    .ADDR_W(ADDR_W), .LINE_SH(LINE_SH), .CW(CW)
  ) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .skip      (skip),
    .ld_start  (cls_start),
    .ld_count  (cls_count),
    .ld_kind   (kind_of(cls_gran)),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_kind  (kind_q),
    .busy      (busy),
    .done      (done),
    .hs        (hs),
    .last_hs   (last_hs)
  );

  assign cmd_kind = kind_q;

  rfs_stats #(
    .STAT_W(STAT_W)
  ) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (accept),
    .gran     (eff_gran),
    .total    (cnt_total),
    .per_gran (per_gran)
  );

  assign cnt_line = per_gran[GR_LINE];
  assign cnt_page = per_gran[GR_PAGE];
  assign cnt_seg  = per_gran[GR_SEG];
  assign cnt_reg  = per_gran[GR_REG];
  assign cnt_ctx  = per_gran[GR_CTX];

endmodule

// File: rtl/range_flush_seq_chk.sv
module range_flush_seq_chk #(
  parameter int ADDR_W  = 32,
  parameter int LINE_SH = 5,
  parameter int STAT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cache_en,
  input logic              req_ready,
  input logic              accept,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [1:0]        cmd_kind,
  input logic              busy,
  input logic              done,
  input logic              hs,
  input logic              last_hs,
  input logic [STAT_W-1:0] cnt_total
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << LINE_SH;

  a_r1_disabled_done: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cache_en |=> done && !busy && !cmd_valid);

  a_r7_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr[LINE_SH-1:0] == '0));

  a_r7_step_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !last_hs |=> cmd_valid && (cmd_addr == $past(cmd_addr) + STEP));

  a_r7_kind_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !last_hs |=> $stable(cmd_kind));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_kind));

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_hs |=> done && !busy);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_total_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cnt_total == $past(cnt_total) + STAT_W'(1));

  a_r10_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cnt_total));

endmodule

bind range_flush_seq range_flush_seq_chk #(
  .ADDR_W(ADDR_W), .LINE_SH(LINE_SH), .STAT_W(STAT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cache_en  (cache_en),
  .req_ready (req_ready),
  .accept    (accept),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_addr  (cmd_addr),
  .cmd_kind  (cmd_kind),
  .busy      (busy),
  .done      (done),
  .hs        (hs),
  .last_hs   (last_hs),
  .cnt_total (cnt_total)
);

// File: tb/range_flush_seq_test.sv
module range_flush_seq_test;

  // Small geometry: line 16 B, page 256 B, segment 1 KiB, region 4 KiB,
  // cache 1 KiB (64 lines, page threshold 4 pages).
  localparam int AW = 16;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cache_en;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_base;
  logic [AW-1:0] req_len;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr;
  logic [1:0]    cmd_kind;
  logic          busy;
  logic          done;
  logic [SW-1:0] cnt_total, cnt_line, cnt_page, cnt_seg, cnt_reg, cnt_ctx;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  range_flush_seq #(
    .ADDR_W(AW), .LEN_W(AW), .LINE_SH(4), .PAGE_SH(8), .SEG_SH(10),
    .REG_SH(12), .CACHE_SH(10), .STAT_W(SW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_base(req_base), .req_len(req_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_kind(cmd_kind), .busy(busy), .done(done), .cnt_total(cnt_total),
    .cnt_line(cnt_line), .cnt_page(cnt_page), .cnt_seg(cnt_seg),
    .cnt_reg(cnt_reg), .cnt_ctx(cnt_ctx)
  );

  // gran: 0 line, 1 page, 2 segment, 3 region, 4 context, 5 cache off
  typedef struct packed {
    logic          en;
    logic [15:0]   base;
    logic [15:0]   len;
    logic [2:0]    gran;
    logic [15:0]   start;
    logic [15:0]   cnt;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0123, 16'h0020, 3'd0, 16'h0120, 16'd3},   // R2 offset 3
    '{1'b1, 16'h0100, 16'h00FF, 3'd0, 16'h0100, 16'd16},  // R2 just under a page
    '{1'b1, 16'h00FF, 16'h0002, 3'd0, 16'h00F0, 16'd2},   // R2 crosses a line
    '{1'b1, 16'h0045, 16'h0000, 3'd0, 16'h0040, 16'd1},   // R11 zero len, offset
    '{1'b1, 16'h0040, 16'h0000, 3'd0, 16'h0040, 16'd0},   // R11 zero lines
    '{1'b1, 16'h0210, 16'h0100, 3'd1, 16'h0200, 16'd32},  // R3 exactly a page long
    '{1'b1, 16'h0480, 16'h0200, 3'd1, 16'h0400, 16'd48},  // R3 three pages
    '{1'b1, 16'h0800, 16'h0400, 3'd2, 16'h0800, 16'd64},  // R4 at page threshold
    '{1'b1, 16'h0C10, 16'h0300, 3'd2, 16'h0C00, 16'd64},  // R4 offset in segment
    '{1'b1, 16'h1200, 16'h0600, 3'd3, 16'h1000, 16'd64},  // R5 spans 2 segments
    '{1'b1, 16'h2F00, 16'h0400, 3'd4, 16'h0000, 16'd64},  // R6 spans 2 regions
    '{1'b0, 16'h0123, 16'h0020, 3'd5, 16'h0000, 16'd0},   // R1 cache off
    '{1'b0, 16'h2F00, 16'h0400, 3'd5, 16'h0000, 16'd0}    // R1 cache off, large
  };

  task automatic check(input logic ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int idx, input logic [2:0] g);
    if (idx == 3 || idx == 4) return "R11";
    case (g)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [1:0] kind_exp(input logic [2:0] g);
    case (g)
      3'd2: return 2'd1;
      3'd3: return 2'd2;
      3'd4: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    string tag;
    int    n;
    int    cyc;
    int    bad;
    int    held_bad;
    int    first_bad;
    logic  stall;
    logic [AW-1:0] prev_a;
    logic [AW-1:0] exp_a;
    tag = tag_of(idx, v.gran);
    @(negedge clk);
    cache_en  = v.en;
    req_base  = v.base;
    req_len   = v.len;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.cnt == 0) begin
      check(done && !busy && !cmd_valid, tag, "no-work completion {done,busy,valid}",
            {done, busy, cmd_valid}, 3'b100);
    end else begin
      check(busy && !req_ready && cmd_valid, "R9", "busy after accept {busy,ready,valid}",
            {busy, req_ready, cmd_valid}, 3'b101);
      n = 0; cyc = 0; bad = 0; held_bad = 0; first_bad = 0; stall = 1'b0; prev_a = '0;
      while (n < int'(v.cnt) && cyc < 4000) begin
        // a second request offered while busy must be ignored (R9)
        if (idx == 10 && cyc == 0) begin
          req_valid = 1'b1; req_base = 16'h0040; req_len = 16'h0010;
        end else begin
          req_valid = 1'b0;
        end
        if (stall && (!cmd_valid || cmd_addr != prev_a)) held_bad++;
        cmd_ready = (cyc % 3) != 2;
        if (cmd_valid && cmd_ready) begin
          exp_a = v.start + AW'(n * 16);
          if (cmd_addr != exp_a || cmd_kind != kind_exp(v.gran)) begin
            if (bad == 0) first_bad = int'(cmd_addr);
            bad++;
          end
          n++;
        end
        stall  = cmd_valid && !cmd_ready;
        prev_a = cmd_addr;
        cyc++;
        @(negedge clk);
      end
      cmd_ready = 1'b0;
      req_valid = 1'b0;
      check(bad == 0, tag, "R7 command address/kind sequence (first bad addr)",
            first_bad, v.start);
      check(n == int'(v.cnt), tag, "command count", n, v.cnt);
      check(held_bad == 0, "R8", "stalled command changed", held_bad, 0);
      check(done && !busy && !cmd_valid, "R9", "done after last handshake {done,busy,valid}",
            {done, busy, cmd_valid}, 3'b100);
    end
    @(negedge clk);
    check(!done && !cmd_valid, "R9", "done single cycle {done,valid}", {done, cmd_valid}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int exp_g [6];
    int exp_total;
    for (int i = 0; i < 6; i++) exp_g[i] = 0;
    exp_total = 0;
    rst_n = 1'b0; cache_en = 1'b1; req_valid = 1'b0; cmd_ready = 1'b0;
    req_base = '0; req_len = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R9, R10)
    check(!busy && !cmd_valid && !done && req_ready, "R9", "reset {busy,valid,done,ready}",
          {busy, cmd_valid, done, req_ready}, 4'b0001);
    check(cnt_total == 0 && cnt_line == 0 && cnt_ctx == 0, "R10", "reset counters",
          cnt_total, 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], i);
      exp_g[VECS[i].gran]++;
      exp_total++;
      check(cnt_total == SW'(exp_total), "R10", "total after vector", cnt_total, exp_total);
    end

    // Per-granularity counters (R10); the ignored busy request adds nothing.
    check(cnt_line == SW'(exp_g[0]), "R10", "line count", cnt_line, exp_g[0]);
    check(cnt_page == SW'(exp_g[1]), "R10", "page count", cnt_page, exp_g[1]);
    check(cnt_seg  == SW'(exp_g[2]), "R10", "segment count", cnt_seg, exp_g[2]);
    check(cnt_reg  == SW'(exp_g[3]), "R10", "region count", cnt_reg, exp_g[3]);
    check(cnt_ctx  == SW'(exp_g[4]), "R10", "context count", cnt_ctx, exp_g[4]);

    // Directed: reset during a walk returns to idle with counters cleared.
    @(negedge clk);
    cache_en = 1'b1; req_base = 16'h2F00; req_len = 16'h0400; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && cmd_addr == 16'h0000 && cmd_kind == 2'd3, "R6", "context walk first cmd",
          {busy, cmd_addr}, {1'b1, 16'h0000});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !cmd_valid && cnt_total == 0, "R9", "idle after mid-walk reset",
          {busy, cmd_valid}, 2'b00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule